// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits in the transmit path ahead of a MAC. It takes one outgoing Ethernet frame at a time as a byte stream and stores it whole in a local buffer. While the bytes arrive it forms a 16-bit ones'-complement sum over a chosen byte range. Once the frame has ended, the block either drops the frame or replays it on an output byte stream. During replay it can place the finished checksum, most significant byte first, at any offset inside the frame.

Three per-frame sideband inputs control the offload. An enable flag turns insertion on. A 32-bit offset word carries the first summed byte in its upper half and the insertion point in its lower half. A 16-bit seed, usually a pseudo-header partial sum from software, is added in before folding. The block samples all three with the first byte of the frame. Three configuration levels decide whether a frame goes out at all: transmit enable, jumbo enable and VLAN enable. Every frame that leaves the block adds its byte length to a 64-bit counter and sets a sticky completion flag.

Top module: `tx_csum_inserter`

## Requirements
- R1: After reset `s_tready` is 1, `m_tvalid` is 0, `tx_byte_count` is 0 and `tx_done` is 0.
- R2: With `ctl_offload_en` 0, an accepted frame is replayed on the output with the same bytes in the same order, and `m_tlast` is set on its final byte only.
- R3: With `ctl_offload_en` 1 (sampled with the first byte), the inserted value is the complement of the end-around-carry fold of S + `ctl_seed`. S is the sum of 16-bit words taken from offset `ctl_offsets[31:16]` up to the end of the frame. The first byte of each word is its high byte. A start offset at or past the frame end gives S = 0.
- R4: When the summed range has an odd number of bytes, the last byte counts as a high byte with a zero low byte.
- R5: The checksum's high byte replaces the byte at offset W = `ctl_offsets[15:0]` and its low byte replaces offset W+1. No other byte changes. W = length-2 is valid.
- R6: If W > length-2, the frame is replayed unmodified even with offload enabled.
- R7: While `cfg_tx_en` is 0 when a frame completes, the frame produces no output beat and leaves `tx_byte_count` and `tx_done` unchanged.
- R8: With `cfg_jumbo_en` and `cfg_vlan_en` both 0, frames of 1519 to 1522 bytes are dropped. If either flag is 1 they are sent. Frames of 1523 bytes or more are sent.
- R9: Frames longer than `BUF_BYTES` (2048 by default) are dropped. A frame of exactly `BUF_BYTES` is sent.
- R10: Each sent frame adds its length to `tx_byte_count` and sets `tx_done`. `tx_done` stays set until `tx_done_clr` is pulsed.
- R11: While `m_tvalid` is 1 and `m_tready` is 0, `m_tdata` and `m_tlast` hold. No byte is lost or repeated.
- R12: `s_tready` is 0 from the end of an input frame until its output (or drop) completes, so input and output never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 8 | Input frame byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tlast | input | 1 | Final byte of input frame |
| s_tready | output | 1 | Block can accept an input byte |
| ctl_offload_en | input | 1 | Checksum insertion enable for this frame |
| ctl_offsets | input | 32 | [31:16] sum start offset, [15:0] insertion offset |
| ctl_seed | input | 16 | Value added to the sum before folding |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_jumbo_en | input | 1 | Jumbo frames allowed |
| cfg_vlan_en | input | 1 | Tagged-size frames allowed |
| m_tdata | output | 8 | Output frame byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tlast | output | 1 | Final byte of output frame |
| m_tready | input | 1 | Downstream accepts the byte |
| tx_byte_count | output | 64 | Running total of bytes sent |
| tx_done | output | 1 | Sticky frame-sent flag |
| tx_done_clr | input | 1 | Clears `tx_done` |

## Verification
The assertions assume that the sideband control words and configuration levels stay steady for the whole of a frame. They also assume that `m_tready` is an ordinary handshake input that may drop at any cycle, and that `s_tvalid` frames always end with `s_tlast`. The stimulus follows these assumptions. It drives control and configuration only between frames and changes `m_tready` pseudo-randomly one time unit after each rising edge. It only presents input bytes while `s_tready` is seen high, and it keeps every frame terminated and within 2049 bytes, so the saturating length counter is never pushed beyond its drop threshold.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int OFFW = 16;
  typedef enum logic [1:0] {ST_RX, ST_FOLD, ST_TX} tcs_state_e;
endpackage

// File: rtl/tcs_frame_buf.sv
module tcs_frame_buf #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  // simple dual-port, registered read with enable: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // R11: read port holds its word while the pipeline is stalled
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));
endmodule

// File: rtl/tcs_sum_unit.sv
module tcs_sum_unit #(
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            add_vld,
  input  logic [7:0]      add_byte,
  input  logic [OFFW-1:0] add_idx,
  input  logic [OFFW-1:0] start,
  input  logic [15:0]     seed,
  output logic [15:0]     csum
);
  logic [31:0] acc;
  logic        low_half;
  logic [31:0] t0;
  logic [16:0] t1;
  logic [16:0] t2;

  // even distance from start -> high byte of a big-endian word
  assign low_half = add_idx[0] ^ start[0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (add_vld && (add_idx >= start)) begin
      acc <= acc + (low_half ? {24'd0, add_byte} : {16'd0, add_byte, 8'd0});
    end
  end

  always_comb begin
    t0   = acc + {16'd0, seed};
    t1   = {1'b0, t0[31:16]} + {1'b0, t0[15:0]};
    t2   = {1'b0, t1[15:0]} + {16'd0, t1[16]};
    csum = ~t2[15:0];
  end

  // R3: accumulator only grows within a frame
  a_r3_acc_monotonic: assert property (@(posedge clk) disable iff (rst)
    !clr |=> acc >= $past(acc));
endmodule

// File: rtl/tcs_size_gate.sv
module tcs_size_gate #(
  parameter int LW        = 12,
  parameter int BUF_BYTES = 2048,
  parameter int STD_MAX   = 1518,
  parameter int TAG_MAX   = 1522
) (
  input  logic [LW-1:0] frame_len,
  input  logic          tx_en,
  input  logic          jumbo_en,
  input  logic          vlan_en,
  output logic          drop
);
  logic in_tag_band;
  logic too_big;

  always_comb begin
    in_tag_band = (frame_len > LW'(STD_MAX)) && (frame_len <= LW'(TAG_MAX));
    too_big     = frame_len > LW'(BUF_BYTES);
    drop        = !tx_en || too_big || (!jumbo_en && !vlan_en && in_tag_band);
  end
endmodule

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter
  import tcs_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int STD_MAX   = 1518,
  parameter int TAG_MAX   = 1522
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  input  logic        s_tlast,
  output logic        s_tready,
  input  logic        ctl_offload_en,
  input  logic [31:0] ctl_offsets,
  input  logic [15:0] ctl_seed,
  input  logic        cfg_tx_en,
  input  logic        cfg_jumbo_en,
  input  logic        cfg_vlan_en,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  output logic        m_tlast,
  input  logic        m_tready,
  output logic [63:0] tx_byte_count,
  output logic        tx_done,
  input  logic        tx_done_clr
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int LW = AW + 1;

  tcs_state_e      st;
  logic [LW-1:0]   len_q;
  logic [LW-1:0]   rp;
  logic            en_q;
  logic [OFFW-1:0] start_q;
  logic [OFFW-1:0] wr_q;
  logic [15:0]     seed_q;
  logic [15:0]     csum_q;
  logic            patch_q;

  logic            first;
  logic            beat;
  logic            buf_we;
  logic [OFFW-1:0] start_eff;
  logic [OFFW-1:0] wr_idx;
  logic [15:0]     csum;
  logic            drop;
  logic            advance;
  logic            issue;
  logic            fin;
  logic            sum_clr;
  logic [7:0]      rd_byte;
  logic [7:0]      pdata;
  logic            d1v;
  logic            d1_last;
  logic [LW-1:0]   d1_idx;
  logic [OFFW-1:0] d1_idx16;

  assign s_tready  = (st == ST_RX);
  assign beat      = s_tvalid && s_tready;
  assign first     = (len_q == '0);
  assign buf_we    = beat && (len_q < LW'(BUF_BYTES));
  assign start_eff = first ? ctl_offsets[31:16] : start_q;
  assign wr_idx    = {{(OFFW-LW){1'b0}}, len_q};
  assign advance   = !m_tvalid || m_tready;
  assign issue     = (st == ST_TX) && advance && (rp < len_q);
  assign fin       = m_tvalid && m_tready && m_tlast;
  assign sum_clr   = fin || ((st == ST_FOLD) && drop);
  assign d1_idx16  = {{(OFFW-LW){1'b0}}, d1_idx};

  tcs_frame_buf #(.DEPTH(BUF_BYTES), .AW(AW)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .we    (buf_we),
    .waddr (len_q[AW-1:0]),
    .wdata (s_tdata),
    .re    (advance),
    .raddr (rp[AW-1:0]),
    .rdata (rd_byte)
  );

  tcs_sum_unit #(.OFFW(OFFW)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .clr      (sum_clr),
    .add_vld  (buf_we),
    .add_byte (s_tdata),
    .add_idx  (wr_idx),
    .start    (start_eff),
    .seed     (seed_q),
    .csum     (csum)
  );

  tcs_size_gate #(.LW(LW), .BUF_BYTES(BUF_BYTES), .STD_MAX(STD_MAX), .TAG_MAX(TAG_MAX)) u_gate (
    .frame_len (len_q),
    .tx_en     (cfg_tx_en),
    .jumbo_en  (cfg_jumbo_en),
    .vlan_en   (cfg_vlan_en),
    .drop      (drop)
  );

  // byte substitution at the insertion point
  always_comb begin
    pdata = rd_byte;
    if (patch_q && (d1_idx16 == wr_q))         pdata = csum_q[15:8];
    if (patch_q && (d1_idx16 == wr_q + 1'b1))  pdata = csum_q[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_RX;
      len_q         <= '0;
      rp            <= '0;
      en_q          <= 1'b0;
      start_q       <= '0;
      wr_q          <= '0;
      seed_q        <= '0;
      csum_q        <= '0;
      patch_q       <= 1'b0;
      d1v           <= 1'b0;
      d1_last       <= 1'b0;
      d1_idx        <= '0;
      m_tvalid      <= 1'b0;
      m_tdata       <= '0;
      m_tlast       <= 1'b0;
      tx_byte_count <= '0;
    end else begin
      case (st)
        ST_RX: if (beat) begin
          if (first) begin
            en_q    <= ctl_offload_en;
            start_q <= ctl_offsets[31:16];
            wr_q    <= ctl_offsets[15:0];
            seed_q  <= ctl_seed;
          end
          if (len_q <= LW'(BUF_BYTES)) len_q <= len_q + 1'b1;
          if (s_tlast) st <= ST_FOLD;
        end
        ST_FOLD: begin
          if (drop) begin
            st    <= ST_RX;
            len_q <= '0;
          end else begin
            st      <= ST_TX;
            rp      <= '0;
            csum_q  <= csum;
            patch_q <= en_q &&
                       (({1'b0, wr_q} + 17'd2) <= {{(17-LW){1'b0}}, len_q});
          end
        end
        ST_TX: begin
          if (advance) begin
            d1v      <= issue;
            d1_idx   <= rp;
            d1_last  <= (rp == len_q - 1'b1);
            m_tvalid <= d1v;
            m_tdata  <= pdata;
            m_tlast  <= d1_last;
            if (issue) rp <= rp + 1'b1;
          end
          if (fin) begin
            st            <= ST_RX;
            len_q         <= '0;
            tx_byte_count <= tx_byte_count + 64'(len_q);
          end
        end
        default: st <= ST_RX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              tx_done <= 1'b0;
    else if (fin)         tx_done <= 1'b1;
    else if (tx_done_clr) tx_done <= 1'b0;
  end

  // R11: stalled output beat is held
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
  // R12: input and output phases never overlap
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
    s_tready |-> !m_tvalid);
  // R10: counter moves only on the final output handshake
  a_r10_count_only_at_end: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(tx_byte_count));
  // R10: completion flag follows every sent frame
  a_r10_done_set: assert property (@(posedge clk) disable iff (rst)
    fin |=> tx_done);
  // R7: disabled transmit returns straight to input with nothing sent
  a_r7_disabled_drop: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FOLD && !cfg_tx_en) |=> (s_tready && !m_tvalid));
  // R9: oversized frame is not replayed
  a_r9_oversize_drop: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FOLD && len_q > LW'(BUF_BYTES)) |=> (s_tready && $stable(tx_byte_count)));
endmodule

// File: tb/tb_tx_csum_inserter.sv
module tb_tx_csum_inserter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic        s_tready;
  logic        ctl_offload_en = 1'b0;
  logic [31:0] ctl_offsets = '0;
  logic [15:0] ctl_seed = '0;
  logic        cfg_tx_en = 1'b1;
  logic        cfg_jumbo_en = 1'b0;
  logic        cfg_vlan_en = 1'b0;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tlast;
  logic        m_tready = 1'b1;
  logic [63:0] tx_byte_count;
  logic        tx_done;
  logic        tx_done_clr = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tx_csum_inserter dut (
    .clk(clk), .rst(rst),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .ctl_offload_en(ctl_offload_en), .ctl_offsets(ctl_offsets), .ctl_seed(ctl_seed),
    .cfg_tx_en(cfg_tx_en), .cfg_jumbo_en(cfg_jumbo_en), .cfg_vlan_en(cfg_vlan_en),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
    .tx_byte_count(tx_byte_count), .tx_done(tx_done), .tx_done_clr(tx_done_clr)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  int          beats_seen = 0;
  bit          bp_mode = 1'b0;
  bit          finished = 1'b0;
  longint      exp_total = 0;
  logic [8:0]  exp_q[$];
  string       tag_q[$];
  logic [7:0]  fr [0:2100];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ready driver, away from the active edge
  initial forever begin
    @(posedge clk);
    #1 m_tready <= bp_mode ? (($urandom % 4) != 0) : 1'b1;
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (!rst && m_tvalid && m_tready) begin
      beats_seen++;
      check(!s_tready, "R12 input open during output", 64'(s_tready), 64'd0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected output beat", 64'({m_tlast, m_tdata}), 64'h0);
      end else begin
        logic [8:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({m_tlast, m_tdata} == e, t, 64'({m_tlast, m_tdata}), 64'(e));
      end
    end
  end

  task automatic make_frame(input int len, input int k);
    for (int i = 0; i < len; i++) fr[i] = 8'((i * 37 + k * 11 + (i >> 3)) & 255);
  endtask

  function automatic logic [15:0] ref_csum(input int len, input int start, input int seed);
    longint unsigned s = 0;
    for (int i = start; i < len; i++)
      s += (((i - start) % 2) == 0) ? (longint'(fr[i]) << 8) : longint'(fr[i]);
    s += longint'(seed);
    while ((s >> 16) != 0) s = (s & 64'hffff) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic send(input int len, input bit en, input int start, input int wr,
                      input int seed, input bit expect_out, input string tag);
    logic [15:0] cs;
    bit          patch;
    cs    = ref_csum(len, start, seed);
    patch = en && (len >= 2) && (wr <= len - 2);
    if (expect_out) begin
      for (int i = 0; i < len; i++) begin
        logic [7:0] d;
        d = fr[i];
        if (patch && i == wr)     d = cs[15:8];
        if (patch && i == wr + 1) d = cs[7:0];
        exp_q.push_back({(i == len - 1), d});
        tag_q.push_back(tag);
      end
      exp_total += len;
    end
    ctl_offload_en = en;
    ctl_offsets    = {16'(start), 16'(wr)};
    ctl_seed       = 16'(seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!s_tready) @(negedge clk);
      s_tvalid = 1'b1;
      s_tdata  = fr[i];
      s_tlast  = (i == len - 1);
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || !s_tready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    int b0;
    longint c0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(s_tready == 1'b1, "R1 s_tready", 64'(s_tready), 64'd1);
    check(m_tvalid == 1'b0, "R1 m_tvalid", 64'(m_tvalid), 64'd0);
    check(tx_byte_count == 0, "R1 tx_byte_count", tx_byte_count, 64'd0);
    check(tx_done == 1'b0, "R1 tx_done", 64'(tx_done), 64'd0);

    // R2 pass-through
    make_frame(60, 1);
    send(60, 1'b0, 14, 24, 16'h1234, 1'b1, "R2 passthrough");
    drain();
    check(tx_byte_count == 64'd60, "R10 count after first", tx_byte_count, 64'd60);
    check(tx_done == 1'b1, "R10 done set", 64'(tx_done), 64'd1);
    tx_done_clr = 1'b1;
    @(negedge clk);
    tx_done_clr = 1'b0;
    @(negedge clk);
    check(tx_done == 1'b0, "R10 done cleared", 64'(tx_done), 64'd0);

    // R3/R5 even span, R4 odd span
    make_frame(60, 2);
    send(60, 1'b1, 14, 24, 16'h1234, 1'b1, "R3 R5 even span insert");
    drain();
    make_frame(61, 3);
    send(61, 1'b1, 14, 40, 16'hfedc, 1'b1, "R4 odd span insert");
    drain();
    make_frame(33, 4);
    send(33, 1'b1, 50, 4, 16'h00ff, 1'b1, "R3 start beyond end");
    drain();

    // R11 backpressure from here on
    bp_mode = 1'b1;
    make_frame(64, 5);
    send(64, 1'b1, 0, 62, 16'hffff, 1'b1, "R5 R11 insert at len-2");
    drain();
    make_frame(64, 6);
    send(64, 1'b1, 0, 63, 16'h0001, 1'b1, "R6 offset len-1 unmodified");
    drain();
    make_frame(50, 7);
    send(50, 1'b1, 2, 1000, 16'h0, 1'b1, "R6 offset far beyond");
    drain();
    make_frame(1, 8);
    send(1, 1'b0, 0, 0, 16'h0, 1'b1, "R2 single byte");
    drain();

    // R7 transmit disabled
    cfg_tx_en = 1'b0;
    b0 = beats_seen; c0 = longint'(tx_byte_count);
    make_frame(40, 9);
    send(40, 1'b1, 0, 10, 16'h55, 1'b0, "R7");
    drain();
    check(beats_seen == b0, "R7 no beats when disabled", 64'(beats_seen), 64'(b0));
    check(tx_byte_count == 64'(c0), "R7 count unchanged", tx_byte_count, 64'(c0));
    cfg_tx_en = 1'b1;

    // R8 size band
    b0 = beats_seen;
    make_frame(1520, 10);
    send(1520, 1'b0, 0, 0, 0, 1'b0, "R8");
    drain();
    check(beats_seen == b0, "R8 1520 dropped", 64'(beats_seen), 64'(b0));
    cfg_vlan_en = 1'b1;
    send(1522, 1'b1, 14, 30, 16'h2222, 1'b1, "R8 1522 with vlan");
    drain();
    cfg_vlan_en = 1'b0;
    make_frame(1523, 11);
    send(1523, 1'b1, 20, 1500, 16'h0, 1'b1, "R8 1523 passes");
    drain();
    cfg_jumbo_en = 1'b1;
    send(1519, 1'b0, 0, 0, 0, 1'b1, "R8 1519 with jumbo");
    drain();

    // R9 buffer limit
    b0 = beats_seen; c0 = longint'(tx_byte_count);
    make_frame(2049, 12);
    send(2049, 1'b1, 0, 8, 0, 1'b0, "R9");
    drain();
    check(beats_seen == b0, "R9 oversize dropped", 64'(beats_seen), 64'(b0));
    check(tx_byte_count == 64'(c0), "R9 count unchanged", tx_byte_count, 64'(c0));
    send(2048, 1'b1, 0, 2046, 16'h1357, 1'b1, "R9 full buffer sent");
    drain();

    check(tx_byte_count == 64'(exp_total), "R10 total count", tx_byte_count, 64'(exp_total));
    check(exp_q.size() == 0, "R2 all bytes seen", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule